// File: doc/BRIEF.md
# Floating-point register stack controller

This block holds the register file of a floating-point unit, organised as an eight-deep circular stack. A top pointer names the physical entry that is currently ST(0), and every access is made relative to it. ST(i) resolves to physical entry (top + i) mod 8. Each entry stores a data word and a 2-bit class tag. A control word and a status word are kept alongside the stack.

One command is accepted per clock. The commands are: push a data word, push the constant zero, pop, exchange ST(0) with ST(i), copy ST(0) into ST(i), initialise, and clear the exception flags. Two combinational read ports return the value and the tag of any stack-relative slot. The full tag array is also presented as one packed word.

Stack misuse is only reported. Pushing onto an occupied slot or popping an empty one raises a one-cycle fault pulse and sets the matching status flags, and the command still executes. The top pointer is copied into the status word when the surrounding logic strobes a status read.

Top module: `fp_stack_ctrl`

## Requirements
- R1: After reset the control word is 0x037F, the status word is 0x0000, all eight tags are empty (11), the top pointer is 0 and `stack_fault` is low.
- R2: Read port r returns the value and tag of physical entry (top + rd_idx[r]) mod 8 in the same cycle. The tag codes are 00 valid, 01 zero, 10 special and 11 empty.
- R3: A push (op 1) first moves top to (top - 1) mod 8, then stores `cmd_data` there with tag 00. After the edge the new word is ST(0) and the old ST(i) is ST(i+1).
- R4: A zero push (op 2) behaves as a push but stores the value 0 with tag 01.
- R5: A pop (op 3) sets the tag of the current ST(0) to 11 and then moves top to (top + 1) mod 8.
- R6: An exchange (op 4) swaps the value and tag of ST(0) and ST(cmd_idx). With cmd_idx = 0 nothing changes.
- R7: A copy (op 5) writes the value and tag of ST(0) into ST(cmd_idx) and leaves ST(0) unchanged.
- R8: Initialise (op 6) loads the control word with 0x037F, clears the status word, marks every tag 11 and sets top to 0.
- R9: Clear-exceptions (op 7) replaces the status word with status AND 0x7F00.
- R10: A push whose target slot is not empty, or a pop whose ST(0) is empty, still executes. It sets status bits 0 and 6, and sets status bit 9 to 1 for a push or 0 for a pop. `stack_fault` is high for exactly the following cycle.
- R11: When `status_rd` is high, status bits 13:11 take the top value that results from that cycle's command. Without the strobe those bits keep their value.
- R12: `tag_word` bits 2k+1:2k hold the tag of physical entry k.
- R13: While `cmd_valid` is low, no tag, value, top, control or status bit changes, whatever `cmd_op` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 0 none, 1 push, 2 push zero, 3 pop, 4 exchange, 5 copy, 6 initialise, 7 clear exceptions |
| cmd_idx | input | PW | Stack-relative index i for exchange and copy |
| cmd_data | input | W | Word stored by a push |
| status_rd | input | 1 | Status read strobe; copies top into status bits 13:11 |
| rd_idx | input | NRD*PW | Stack-relative index of each read port |
| rd_data | output | NRD*W | Value read by each port |
| rd_tag | output | NRD*2 | Tag read by each port |
| ctrl_word | output | 16 | Control word |
| status_word | output | 16 | Status word |
| tag_word | output | 2*2^PW | Packed tags, two bits per physical entry |
| stack_fault | output | 1 | One-cycle stack misuse pulse |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes both. A status read strobe can arrive together with a push, a pop, an initialise or a clear-exceptions. A fault flag update can arrive together with the top mirror. In the first case the mirrored field must show the post-command top: one below the old value for a push, and 0 for an initialise. In the second case, an overflowing ninth push issued with the strobe must set the fault bits and also write the new top, without one clobbering the other. A behavioural model of the stack, written with plain arrays, is stepped on each command and compared with every output on every cycle, including a sweep of all eight relative read indices on both ports.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_PUSHZ = 3'd2,
    OP_POP   = 3'd3,
    OP_XCHG  = 3'd4,
    OP_COPY  = 3'd5,
    OP_INIT  = 3'd6,
    OP_CLEX  = 3'd7
  } op_e;

  localparam logic [15:0] CW_INIT    = 16'h037F;
  localparam logic [15:0] SW_KEEP    = 16'h7F00;
  localparam logic [15:0] SW_FAULT   = 16'h0041;
  localparam int          SW_C1_BIT  = 9;
  localparam int          SW_TOP_LSB = 11;

endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic          init_en,
  output logic [PW-1:0] top_q,
  output logic [PW-1:0] top_nxt
);

  logic upd_en;

  always_comb begin
    top_nxt = top_q;
    if (init_en)      top_nxt = '0;
    else if (push_en) top_nxt = top_q - PW'(1);
    else if (pop_en)  top_nxt = top_q + PW'(1);
  end

  assign upd_en = init_en | push_en | pop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (upd_en) top_q <= top_nxt;
  end

endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
  import fpstk_pkg::*;
#(
  parameter int W   = 64,
  parameter int PW  = 3,
  parameter int NRD = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_en,
  // write port A: value write optional (pop only retags)
  input  logic                  wa_en,
  input  logic                  wa_val_we,
  input  logic [PW-1:0]         wa_addr,
  input  logic [W-1:0]          wa_val,
  input  logic [1:0]            wa_tag,
  // write port B: value and tag, wins over A on the same entry
  input  logic                  wb_en,
  input  logic [PW-1:0]         wb_addr,
  input  logic [W-1:0]          wb_val,
  input  logic [1:0]            wb_tag,
  // internal lookups for the controller
  input  logic [PW-1:0]         qa_addr,
  output logic [W-1:0]          qa_val,
  output logic [1:0]            qa_tag,
  input  logic [PW-1:0]         qb_addr,
  output logic [W-1:0]          qb_val,
  output logic [1:0]            qb_tag,
  // external read ports, physical addresses
  input  logic [NRD*PW-1:0]     rd_addr,
  output logic [NRD*W-1:0]      rd_val,
  output logic [NRD*2-1:0]      rd_tag,
  output logic [2*(1<<PW)-1:0]  tag_word
);

  localparam int NREG = 1 << PW;

  logic [W-1:0] val_q [NREG];
  logic [1:0]   tag_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_entry
    logic         hit_a;
    logic         hit_b;
    logic         val_we;
    logic         tag_we;
    logic [W-1:0] val_nxt;
    logic [1:0]   tag_nxt;

    assign hit_a = wa_en && (wa_addr == PW'(k));
    assign hit_b = wb_en && (wb_addr == PW'(k));

    always_comb begin
      val_nxt = val_q[k];
      tag_nxt = tag_q[k];
      if (hit_a) begin
        tag_nxt = wa_tag;
        if (wa_val_we) val_nxt = wa_val;
      end
      if (hit_b) begin
        tag_nxt = wb_tag;
        val_nxt = wb_val;
      end
      if (init_en) tag_nxt = TAG_EMPTY;
    end

    assign val_we = hit_b | (hit_a & wa_val_we);
    assign tag_we = hit_a | hit_b | init_en;

    always_ff @(posedge clk) begin
      if (val_we) val_q[k] <= val_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q[k] <= TAG_EMPTY;
      else if (tag_we) tag_q[k] <= tag_nxt;
    end

    assign tag_word[2*k +: 2] = tag_q[k];
  end

  assign qa_val = val_q[qa_addr];
  assign qa_tag = tag_q[qa_addr];
  assign qb_val = val_q[qb_addr];
  assign qb_tag = tag_q[qb_addr];

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_val[r*W +: W] = val_q[rd_addr[r*PW +: PW]];
    assign rd_tag[r*2 +: 2] = tag_q[rd_addr[r*PW +: PW]];
  end

endmodule

// File: rtl/fpstk_status.sv
module fpstk_status
  import fpstk_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_en,
  input  logic          clex_en,
  input  logic          fault_en,
  input  logic          fault_ovf,
  input  logic          mirror_en,
  input  logic [PW-1:0] top_nxt,
  output logic [15:0]   cw_q,
  output logic [15:0]   sw_q,
  output logic          fault_q
);

  logic [15:0] sw_nxt;
  logic        sw_we;

  always_comb begin
    sw_nxt = sw_q;
    if (init_en)      sw_nxt = '0;
    else if (clex_en) sw_nxt = sw_q & SW_KEEP;
    if (fault_en) begin
      sw_nxt            = sw_nxt | SW_FAULT;
      sw_nxt[SW_C1_BIT] = fault_ovf;
    end
    if (mirror_en) sw_nxt[SW_TOP_LSB +: PW] = top_nxt;
  end

  assign sw_we = init_en | clex_en | fault_en | mirror_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cw_q <= CW_INIT;
    else if (init_en) cw_q <= CW_INIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= '0;
    else if (sw_we) sw_q <= sw_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_en;
  end

endmodule

// File: rtl/fp_stack_ctrl.sv
module fp_stack_ctrl
  import fpstk_pkg::*;
#(
  parameter int W   = 64,
  parameter int PW  = 3,
  parameter int NRD = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [PW-1:0]         cmd_idx,
  input  logic [W-1:0]          cmd_data,
  input  logic                  status_rd,
  input  logic [NRD*PW-1:0]     rd_idx,
  output logic [NRD*W-1:0]      rd_data,
  output logic [NRD*2-1:0]      rd_tag,
  output logic [15:0]           ctrl_word,
  output logic [15:0]           status_word,
  output logic [2*(1<<PW)-1:0]  tag_word,
  output logic                  stack_fault
);

  op_e           op;
  logic          push_en, pushz_en, push_any, pop_en;
  logic          xchg_en, copy_en, init_en, clex_en;
  logic [PW-1:0] top_q, top_nxt;
  logic [PW-1:0] push_slot, rel_slot;
  logic [PW-1:0] qa_addr;
  logic [W-1:0]  qa_val, qb_val;
  logic [1:0]    qa_tag, qb_tag;
  logic          ovf, unf;
  logic          wa_en, wa_val_we, wb_en;
  logic [PW-1:0] wa_addr;
  logic [W-1:0]  wa_val;
  logic [1:0]    wa_tag;
  logic [NRD*PW-1:0] rd_phys;

  // command decode
  assign op       = op_e'(cmd_op);
  assign push_en  = cmd_valid && (op == OP_PUSH);
  assign pushz_en = cmd_valid && (op == OP_PUSHZ);
  assign push_any = push_en | pushz_en;
  assign pop_en   = cmd_valid && (op == OP_POP);
  assign xchg_en  = cmd_valid && (op == OP_XCHG);
  assign copy_en  = cmd_valid && (op == OP_COPY);
  assign init_en  = cmd_valid && (op == OP_INIT);
  assign clex_en  = cmd_valid && (op == OP_CLEX);

  // stack-relative address arithmetic
  assign push_slot = top_q - PW'(1);
  assign rel_slot  = top_q + cmd_idx;
  assign qa_addr   = push_any ? push_slot : top_q;

  for (genvar r = 0; r < NRD; r++) begin : g_map
    assign rd_phys[r*PW +: PW] = top_q + rd_idx[r*PW +: PW];
  end

  // misuse detection
  assign ovf = push_any && (qa_tag != TAG_EMPTY);
  assign unf = pop_en   && (qa_tag == TAG_EMPTY);

  // write port A: push, pop retag, exchange ST(0) side
  always_comb begin
    wa_en     = push_any | pop_en | xchg_en;
    wa_val_we = push_any | xchg_en;
    wa_addr   = qa_addr;
    wa_val    = qb_val;
    wa_tag    = qb_tag;
    if (push_any) begin
      wa_val = pushz_en ? '0 : cmd_data;
      wa_tag = pushz_en ? TAG_ZERO : TAG_VALID;
    end else if (pop_en) begin
      wa_tag = TAG_EMPTY;
    end
  end

  // write port B: ST(i) side of exchange and copy, sourced from ST(0)
  assign wb_en = xchg_en | copy_en;

  fpstk_ptr #(.PW(PW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_en (push_any),
    .pop_en  (pop_en),
    .init_en (init_en),
    .top_q   (top_q),
    .top_nxt (top_nxt)
  );

  fpstk_regfile #(.W(W), .PW(PW), .NRD(NRD)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_en   (init_en),
    .wa_en     (wa_en),
    .wa_val_we (wa_val_we),
    .wa_addr   (wa_addr),
    .wa_val    (wa_val),
    .wa_tag    (wa_tag),
    .wb_en     (wb_en),
    .wb_addr   (rel_slot),
    .wb_val    (qa_val),
    .wb_tag    (qa_tag),
    .qa_addr   (qa_addr),
    .qa_val    (qa_val),
    .qa_tag    (qa_tag),
    .qb_addr   (rel_slot),
    .qb_val    (qb_val),
    .qb_tag    (qb_tag),
    .rd_addr   (rd_phys),
    .rd_val    (rd_data),
    .rd_tag    (rd_tag),
    .tag_word  (tag_word)
  );

  fpstk_status #(.PW(PW)) u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_en   (init_en),
    .clex_en   (clex_en),
    .fault_en  (ovf | unf),
    .fault_ovf (ovf),
    .mirror_en (status_rd),
    .top_nxt   (top_nxt),
    .cw_q      (ctrl_word),
    .sw_q      (status_word),
    .fault_q   (stack_fault)
  );

endmodule

// File: rtl/fp_stack_ctrl_chk.sv
module fp_stack_ctrl_chk #(
  parameter int PW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_op,
  input logic                 status_rd,
  input logic [15:0]          ctrl_word,
  input logic [15:0]          status_word,
  input logic [2*(1<<PW)-1:0] tag_word,
  input logic                 stack_fault,
  input logic [PW-1:0]        top_q
);

  function automatic logic [1:0] tag_at(input logic [2*(1<<PW)-1:0] tw,
                                        input logic [PW-1:0] a);
    return tw[2*a +: 2];
  endfunction

  assert_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=>
      (top_q == PW'($past(top_q) - PW'(1))) && (tag_at(tag_word, top_q) == 2'b00));

  assert_push_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> (tag_at(tag_word, top_q) == 2'b01));

  assert_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3) |=>
      (top_q == PW'($past(top_q) + PW'(1))) && (tag_at(tag_word, $past(top_q)) == 2'b11));

  assert_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6) |=>
      (ctrl_word == 16'h037F) && (&tag_word) && (top_q == '0));

  assert_clex_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7 && !status_rd) |=>
      (status_word[7:0] == 8'h00) && (status_word[15:8] == $past(status_word[15:8])));

  assert_fault_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |-> $past(cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd3)));

  assert_mirror_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (status_word[11 +: PW] == top_q));

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !status_rd) |=>
      $stable(tag_word) && $stable(top_q) && $stable(status_word) && $stable(ctrl_word));

endmodule

bind fp_stack_ctrl fp_stack_ctrl_chk #(.PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .status_rd   (status_rd),
  .ctrl_word   (ctrl_word),
  .status_word (status_word),
  .tag_word    (tag_word),
  .stack_fault (stack_fault),
  .top_q       (top_q)
);

// File: tb/fp_stack_ctrl_bench.sv
`timescale 1ns/100ps
module fp_stack_ctrl_bench;

  localparam int W   = 64;
  localparam int PW  = 3;
  localparam int NRD = 2;

  logic              clk;
  logic              rst_n;
  logic              cmd_valid;
  logic [2:0]        cmd_op;
  logic [PW-1:0]     cmd_idx;
  logic [W-1:0]      cmd_data;
  logic              status_rd;
  logic [NRD*PW-1:0] rd_idx;
  logic [NRD*W-1:0]  rd_data;
  logic [NRD*2-1:0]  rd_tag;
  logic [15:0]       ctrl_word;
  logic [15:0]       status_word;
  logic [15:0]       tag_word;
  logic              stack_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference
  logic [W-1:0] m_val [8];
  logic [1:0]   m_tag [8];
  int           m_top;
  logic [15:0]  m_cw, m_sw;
  logic         m_fault;

  fp_stack_ctrl #(.W(W), .PW(PW), .NRD(NRD)) u_fp_stack_ctrl (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_idx (cmd_idx), .cmd_data (cmd_data), .status_rd (status_rd),
    .rd_idx (rd_idx), .rd_data (rd_data), .rd_tag (rd_tag),
    .ctrl_word (ctrl_word), .status_word (status_word), .tag_word (tag_word),
    .stack_fault (stack_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_init();
    for (int k = 0; k < 8; k++) m_tag[k] = 2'b11;
    m_top = 0; m_cw = 16'h037F; m_sw = 16'h0000; m_fault = 1'b0;
  endtask

  task automatic model_step(bit v, int op, int idx, logic [W-1:0] d, bit srd);
    bit f = 0, ovf = 0;
    int p;
    logic [W-1:0] tv;
    logic [1:0] tt;
    if (v) begin
      case (op)
        1, 2: begin
          p = (m_top + 7) % 8;
          f = (m_tag[p] != 2'b11); ovf = 1;
          m_top = p;
          m_val[p] = (op == 2) ? '0 : d;
          m_tag[p] = (op == 2) ? 2'b01 : 2'b00;
        end
        3: begin
          f = (m_tag[m_top] == 2'b11);
          m_tag[m_top] = 2'b11;
          m_top = (m_top + 1) % 8;
        end
        4: begin
          p = (m_top + idx) % 8;
          tv = m_val[p]; tt = m_tag[p];
          m_val[p] = m_val[m_top]; m_tag[p] = m_tag[m_top];
          m_val[m_top] = tv; m_tag[m_top] = tt;
        end
        5: begin
          p = (m_top + idx) % 8;
          m_val[p] = m_val[m_top]; m_tag[p] = m_tag[m_top];
        end
        6: model_init();
        7: m_sw = m_sw & 16'h7F00;
        default: ;
      endcase
    end
    if (f) begin
      m_sw = m_sw | 16'h0041;
      m_sw[9] = ovf;
    end
    m_fault = f;
    if (srd) m_sw[13:11] = 3'(m_top);
  endtask

  // compares every output with the model; sweeps both read ports
  task automatic compare_all(string req);
    logic [15:0] etw;
    int p0, p1;
    for (int k = 0; k < 8; k++) etw[2*k +: 2] = m_tag[k];
    check(req, "ctrl_word", 64'(ctrl_word), 64'(m_cw));
    check(req, "status_word", 64'(status_word), 64'(m_sw));
    check(req, "stack_fault", 64'(stack_fault), 64'(m_fault));
    check("R12", "tag_word", 64'(tag_word), 64'(etw));
    for (int k = 0; k < 8; k++) begin
      rd_idx = {3'(7 - k), 3'(k)};
      #0.4;
      p0 = (m_top + k) % 8;
      p1 = (m_top + 7 - k) % 8;
      check("R2", "rd_tag port0", 64'(rd_tag[1:0]), 64'(m_tag[p0]));
      check("R2", "rd_tag port1", 64'(rd_tag[3:2]), 64'(m_tag[p1]));
      if (m_tag[p0] != 2'b11) check("R2", "rd_data port0", rd_data[63:0], m_val[p0]);
      if (m_tag[p1] != 2'b11) check("R2", "rd_data port1", rd_data[127:64], m_val[p1]);
    end
  endtask

  // issued at a falling edge; returns before the next rising edge
  task automatic cmd(string req, bit v, int op, int idx, logic [W-1:0] d, bit srd);
    cmd_valid = v; cmd_op = 3'(op); cmd_idx = 3'(idx); cmd_data = d; status_rd = srd;
    @(posedge clk);
    model_step(v, op, idx, d, srd);
    #1;
    cmd_valid = 1'b0; status_rd = 1'b0; cmd_op = 3'd0;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_idx = '0;
    cmd_data = '0; status_rd = 1'b0; rd_idx = '0;
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    cmd("R13", 0, 1, 0, 64'hDEAD, 0);             // idle with push code on the bus
    cmd("R3", 1, 1, 0, 64'h1111_0000_AAAA_0001, 0);
    cmd("R3", 1, 1, 0, 64'h2222_0000_BBBB_0002, 0);
    cmd("R3", 1, 1, 0, 64'h3333_0000_CCCC_0003, 0);
    cmd("R4", 1, 2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    cmd("R6", 1, 4, 2, '0, 0);
    cmd("R6", 1, 4, 0, '0, 0);                    // self-exchange
    cmd("R7", 1, 5, 5, '0, 0);                    // copy into empty slot
    cmd("R7", 1, 5, 1, '0, 0);
    cmd("R11", 0, 0, 0, '0, 1);                   // mirror without command
    cmd("R11", 1, 3, 0, '0, 1);                   // pop together with mirror
    cmd("R5", 1, 3, 0, '0, 0);
    cmd("R5", 1, 3, 0, '0, 0);
    cmd("R5", 1, 3, 0, '0, 0);
    cmd("R10", 1, 3, 0, '0, 0);                   // underflow
    cmd("R10", 0, 0, 0, '0, 0);                   // pulse must drop
    cmd("R5", 1, 3, 0, '0, 0);
    cmd("R9", 1, 7, 0, '0, 0);
    for (int k = 0; k < 8; k++) cmd("R3", 1, 1, 0, 64'(k * 64'h0101_0101 + 5), 0);
    cmd("R10", 1, 1, 0, 64'hCAFE_F00D, 1);        // overflow with mirror
    cmd("R10", 1, 2, 0, '0, 0);                   // zero push overflow
    cmd("R9", 1, 7, 0, '0, 1);                    // clear with mirror
    cmd("R13", 0, 6, 0, '0, 0);                   // idle with init code on the bus
    cmd("R8", 1, 6, 0, '0, 1);
    cmd("R3", 1, 1, 0, 64'h0123_4567_89AB_CDEF, 1);
    cmd("R6", 1, 4, 3, '0, 0);                    // exchange with empty slot
    cmd("R8", 1, 6, 0, '0, 0);
    finish_run();
  end

endmodule